// File: doc/BRIEF.md
# Lockable Cache Way Victim Selector

This block decides which way of a set-associative cache receives the new line when a miss occurs. It keeps a round-robin counter for every set and a single 32-bit lockdown register. The register sets a boundary way: the low ways below the boundary are never picked, so software can keep lines in them. Software can also force a miss to replace a named way. This lets it fill the low ways one at a time and then fence them off.

A parameter selects one of two forcing schemes. In the one-shot scheme, a register write arms every set. The first miss in each set then goes to the programmed way. In the flagged scheme, a flag bit in the register forces every miss to the programmed way for as long as the flag stays set. The miss port takes a set index with a valid strobe. The chosen way is returned combinationally in the same cycle.

Top module: `way_victim_sel`

## Requirements
- R1: A read of `reg_rdata` returns all 32 bits of the most recent `reg_wdata` written with `reg_wr`, including bits the decoder ignores. The new value is visible from the clock edge that takes the write.
- R2: After reset, `reg_rdata` is zero and no set has a forced replacement pending. Consecutive misses in one set pick ways 0, 1, 2, 3 and then 0 again.
- R3: Each set has its own round-robin counter. Within the allowed range, a miss takes the counter's way, or the boundary way if the counter is below the boundary. The counter then moves to the next way, and from the highest way it wraps to the boundary way. A miss in one set does not move another set's counter.
- R4: One-shot scheme (MODE=0): the way number sits in bits [WAY_W-1:0]. A write arms every set. The first miss in each set after the write picks that way, whenever that miss comes. A further write arms every set again.
- R5: One-shot scheme: after its forced miss, a set only picks ways greater than or equal to the programmed way, until the next write.
- R6: Flagged scheme (MODE=1): bit 31 is the force flag and bits [WAY_W-1:0] are the way number. Bits 30 down to WAY_W change neither the forced way nor the boundary.
- R7: Flagged scheme with the flag set: every miss in every set picks the programmed way.
- R8: Flagged scheme with the flag clear: misses pick only ways at or above the programmed way. This holds whether the previous write had the flag set, or had the flag clear with a larger way.
- R9: When the boundary equals the highest way, every miss picks the highest way.
- R10: `victim_way` is valid in the same cycle as `miss_valid`. The set's counter and pending state change at the next clock edge, so back-to-back misses in one set see the updated state.
- R11: Writing way i with the force flag set, for i = 0..N-1, and missing into several sets after each write, fills way i of those sets. A final write with the flag clear and way N then keeps ways 0..N-1 out of replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the lockdown register |
| reg_wdata | input | 32 | Lockdown register write data |
| reg_rdata | output | 32 | Lockdown register read data |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_set | input | $clog2(SETS) | Set index of the miss |
| victim_way | output | WAY_W | Way chosen to be replaced |

## Verification
The hardest state to reach from the ports is a set whose counter lies below a newly raised boundary, or a set that stays armed for a forced miss long after the write that armed it. The stimulus first advances chosen sets' counters with plain misses and then reprograms the register. It then misses into untouched, partly advanced and wrapped sets in turn, so the clamp to the boundary, the deferred forced miss and the wrap to the boundary each appear. Both schemes are built side by side on shared stimulus, and the full lock-one-way-at-a-time sequence is checked on both at once.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
    localparam int REG_W    = 32;
    localparam int FLAG_BIT = 31;

    typedef enum logic {
        LOCK_ONESHOT = 1'b0,
        LOCK_FLAGGED = 1'b1
    } lock_mode_e;
endpackage

// File: rtl/wvs_decode.sv
module wvs_decode
    import wvs_pkg::*;
#(
    parameter int         WAYS  = 4,
    parameter int         WAY_W = 2,
    parameter lock_mode_e MODE  = LOCK_ONESHOT
) (
    input  logic [WAY_W-1:0] way_raw,
    input  logic             flag_bit,
    output logic [WAY_W-1:0] bound_way,
    output logic             force_all
);
    localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

    // Clamp only exists when the way field can name a way that is not built.
    generate
        if (WAYS == (1 << WAY_W)) begin : g_full
            assign bound_way = way_raw;
        end else begin : g_clamp
            assign bound_way = (way_raw > TOP) ? TOP : way_raw;
        end
    endgenerate

    assign force_all = flag_bit & (MODE == LOCK_FLAGGED);
endmodule

// File: rtl/wvs_pick.sv
module wvs_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAY_W-1:0] ctr,
    input  logic [WAY_W-1:0] bound_way,
    input  logic             force_en,
    output logic [WAY_W-1:0] victim,
    output logic [WAY_W-1:0] ctr_nxt
);
    localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

    always_comb begin
        if (force_en) begin
            victim = bound_way;
        end else if (ctr < bound_way) begin
            victim = bound_way;
        end else begin
            victim = ctr;
        end
        ctr_nxt = (victim >= TOP) ? bound_way : victim + 1'b1;
    end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import wvs_pkg::*;
#(
    parameter int         WAYS  = 4,
    parameter int         WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int         SETS  = 64,
    parameter lock_mode_e MODE  = LOCK_ONESHOT,
    localparam int        SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             miss_valid,
    input  logic [SET_W-1:0] miss_set,
    output logic [WAY_W-1:0] victim_way
);
    typedef struct packed {
        logic [REG_W-1:0]            lreg;
        logic [SETS-1:0]             pend;
        logic [SETS-1:0][WAY_W-1:0]  ctr;
    } state_t;

    state_t st_d, st_q;

    logic [WAY_W-1:0] bound_way;
    logic             force_all;
    logic             force_en;
    logic [WAY_W-1:0] ctr_nxt;

    wvs_decode #(.WAYS(WAYS), .WAY_W(WAY_W), .MODE(MODE)) u_decode (
        .way_raw   (st_q.lreg[WAY_W-1:0]),
        .flag_bit  (st_q.lreg[FLAG_BIT]),
        .bound_way (bound_way),
        .force_all (force_all)
    );

    assign force_en = (MODE == LOCK_ONESHOT) ? st_q.pend[miss_set] : force_all;

    wvs_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .ctr       (st_q.ctr[miss_set]),
        .bound_way (bound_way),
        .force_en  (force_en),
        .victim    (victim_way),
        .ctr_nxt   (ctr_nxt)
    );

    assign reg_rdata = st_q.lreg;

    always_comb begin
        st_d = st_q;
        if (miss_valid) begin
            st_d.ctr[miss_set]  = ctr_nxt;
            st_d.pend[miss_set] = 1'b0;
        end
        if (reg_wr) begin
            st_d.lreg = reg_wdata;
            if (MODE == LOCK_ONESHOT) begin
                st_d.pend = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wvs_checker.sv
module wvs_checker
    import wvs_pkg::*;
#(
    parameter int         WAYS  = 4,
    parameter int         WAY_W = 2,
    parameter int         SET_W = 6,
    parameter lock_mode_e MODE  = LOCK_ONESHOT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             miss_valid,
    input logic [SET_W-1:0] miss_set,
    input logic [WAY_W-1:0] victim_way
);
    localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);
    localparam logic [WAY_W-1:0] ONE = WAY_W'(1);

    logic [WAY_W-1:0] bnd;
    logic             flag;
    logic             armed;

    always_comb begin
        if (int'(reg_rdata[WAY_W-1:0]) > WAYS - 1) begin
            bnd = TOP;
        end else begin
            bnd = reg_rdata[WAY_W-1:0];
        end
        flag = (MODE == LOCK_FLAGGED) && reg_rdata[FLAG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == $past(reg_wdata));

    // R5 in the one-shot scheme, R8 in the flagged scheme
    assert_victim_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !flag) |-> victim_way >= bnd);

    assert_forced_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && flag) |-> victim_way == bnd);

    assert_rr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && miss_valid && $past(miss_valid) && miss_set == $past(miss_set)
         && !$past(reg_wr) && !flag && $past(victim_way) != TOP)
        |-> victim_way == $past(victim_way) + ONE);

    assert_rr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && miss_valid && $past(miss_valid) && miss_set == $past(miss_set)
         && !$past(reg_wr) && !flag && $past(victim_way) == TOP)
        |-> victim_way == bnd);
endmodule

bind way_victim_sel wvs_checker #(
    .WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W), .MODE(MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .miss_valid (miss_valid),
    .miss_set   (miss_set),
    .victim_way (victim_way)
);

// File: tb/way_victim_sel_tb.sv
module way_victim_sel_tb;
    import wvs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int SETS  = 64;
    localparam int SET_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic             miss_valid = 1'b0;
    logic [SET_W-1:0] miss_set = '0;
    logic [31:0]      rdata0, rdata1;
    logic [WAY_W-1:0] vic0, vic1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    way_victim_sel #(.WAYS(WAYS), .SETS(SETS), .MODE(LOCK_ONESHOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .miss_valid(miss_valid), .miss_set(miss_set),
        .victim_way(vic0));

    way_victim_sel #(.WAYS(WAYS), .SETS(SETS), .MODE(LOCK_FLAGGED)) u_dut_f (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .miss_valid(miss_valid), .miss_set(miss_set),
        .victim_way(vic1));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        miss_valid = 1'b0; reg_wr = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        miss_valid = 1'b0; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // e0: expected way of the one-shot instance, e1: of the flagged one; -1 skips
    task automatic do_miss(input int s, input int e0, input int e1, input string tag);
        @(negedge clk);
        miss_valid = 1'b1; miss_set = SET_W'(s);
        #1;
        if (e0 >= 0) check(32'(vic0), e0, {tag, " oneshot"});
        if (e1 >= 0) check(32'(vic1), e1, {tag, " flagged"});
    endtask

    task automatic do_idle();
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic t_reset_rr();
        do_reset();
        #1;
        check(rdata0, 32'h0, "R2 reset read oneshot");
        check(rdata1, 32'h0, "R2 reset read flagged");
        do_miss(3, 0, 0, "R2 rr0");
        do_miss(3, 1, 1, "R2 rr1 R10 back-to-back");
        do_miss(3, 2, 2, "R2 rr2");
        do_miss(3, 3, 3, "R2 rr3");
        do_miss(3, 0, 0, "R3 wrap to 0");
        do_miss(4, 0, 0, "R3 other set untouched");
        do_idle();
    endtask

    task automatic t_oneshot();
        do_reset();
        do_miss(3, 0, -1, "R3 advance");
        do_miss(3, 1, -1, "R3 advance");
        do_write(32'h0000_0002);
        check(rdata0, 32'h2, "R1 readback");
        do_miss(3, 2, -1, "R4 forced first miss");
        do_miss(3, 3, -1, "R5 above boundary");
        do_miss(3, 2, -1, "R3 wrap to boundary");
        do_miss(9, 2, -1, "R4 other set forced");
        do_miss(9, 3, -1, "R5 other set");
        do_idle();
        repeat (5) @(negedge clk);
        do_miss(60, 2, -1, "R4 deferred forced miss");
        do_miss(0, 2, -1, "R4 set 0 forced");
        do_miss(0, 3, -1, "R5 set 0");
        do_write(32'h0000_0002);
        do_miss(3, 2, -1, "R4 rearm after rewrite");
        do_write(32'h0000_0003);
        do_miss(5, 3, -1, "R9 top forced");
        do_miss(5, 3, -1, "R9 top repeat");
        do_miss(5, 3, -1, "R9 top repeat");
        do_idle();
    endtask

    task automatic t_flagged();
        do_reset();
        do_write(32'h8000_FFFE);
        check(rdata1, 32'h8000_FFFE, "R1 R6 readback full word");
        do_miss(0, -1, 2, "R7 forced set 0");
        do_miss(7, -1, 2, "R7 R6 forced set 7");
        do_miss(7, -1, 2, "R7 forced repeat");
        do_miss(63, -1, 2, "R7 forced set 63");
        do_write(32'h0000_0002);
        do_miss(7, -1, 3, "R8 after flag");
        do_miss(7, -1, 2, "R8 wrap to boundary");
        do_miss(7, -1, 3, "R8 step");
        do_write(32'h7FFF_FFFD);
        check(rdata1, 32'h7FFF_FFFD, "R1 readback middle bits");
        do_miss(12, -1, 1, "R6 R8 middle bits ignored, clamp up");
        do_miss(12, -1, 2, "R8 step");
        do_write(32'h0000_0003);
        do_miss(12, -1, 3, "R9 boundary top");
        do_miss(12, -1, 3, "R9 boundary top repeat");
        do_write(32'h0000_0001);
        do_miss(12, -1, 3, "R8 lower after larger");
        do_miss(12, -1, 1, "R8 wrap to new boundary");
        do_miss(12, -1, 2, "R8 step");
        do_idle();
    endtask

    task automatic t_lock_seq();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            do_write(32'h8000_0000 | 32'(i));
            for (int s = 0; s < 4; s++) begin
                do_miss(s, i, i, "R11 fill way");
            end
            do_idle();
        end
        do_write(32'h0000_0003);
        for (int s = 0; s < 4; s++) begin
            do_miss(s, 3, 3, "R11 locked ways skipped");
            do_miss(s, 3, 3, "R11 R9 locked ways skipped");
        end
        do_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_rr();
        t_oneshot();
        t_flagged();
        t_lock_seq();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule